// File: doc/BRIEF.md
# Prime-Count Interleaved Bank Front End

This block sits between a single request port and a set of independent memory banks, where the number of banks is an odd prime. Each incoming word address is split into a bank index and an in-bank word offset. The bank index is the address reduced modulo the bank count. The offset is the address reduced modulo the per-bank depth, and because that depth is a power of two the offset is simply the low address bits. The two moduli share no common factor, so every address below their product lands on its own (bank, offset) pair. Strides that are multiples of a power of two therefore still spread across the banks instead of piling onto one.

Each bank owns a busy counter. After it accepts an access, a bank refuses new work for a fixed number of cycles. Other banks keep accepting requests during that time, so accesses to different banks overlap. The request port uses a valid/ready handshake. Ready drops only when the bank that the current address selects is still busy.

Every accepted request appears for one cycle on the command outputs. These are a per-bank strobe together with a shared operation, offset and write-data bus. Reads come back on a single return channel after a fixed latency, in the order they were accepted, and each return is tagged with the bank that served it.

Top module: `pmi_bank_front`

## Requirements
- R1: For an accepted request, exactly the strobe of bank (address mod NUM_BANKS) on `bank_cmd_valid` is high; bit b of that vector belongs to bank b. For example, with 3 banks of 8 words, address 16 goes to bank 1, address 8 to bank 2, address 9 to bank 0 and address 23 to bank 2.
- R2: The offset presented on `bank_cmd_off` for an accepted request is the address mod WORDS_PER_BANK, which equals the low log2(WORDS_PER_BANK) address bits. For example, 16 gives 0, 9 gives 1 and 23 gives 7.
- R3: `bank_cmd_valid` has at most one bit set. It is all zero in any cycle without an accepted request. While a strobe is high, `bank_cmd_we` and `bank_cmd_wdata` equal the request's write flag (1 = write, 0 = read) and its data.
- R4: All addresses from 0 to NUM_BANKS*WORDS_PER_BANK-1 map to pairwise distinct (bank, offset) pairs.
- R5: A bank that accepts a request in cycle c cannot accept again before cycle c+BUSY_CYC. In that window `req_ready` is low whenever the requested address selects that bank, and no strobe fires. Requests that select other banks are accepted without waiting.
- R6: A read accepted in cycle c raises `rd_valid` for exactly one cycle, in cycle c+READ_LAT. `rd_data` then carries the word most recently written to that address, or zero if the address has not been written since reset.
- R7: Read returns come out in acceptance order, with `rd_bank` equal to the serving bank's index. Writes produce no return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Selected bank can accept this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Linear word address, below NUM_BANKS*WORDS_PER_BANK |
| req_wdata | input | DATA_W | Write data |
| bank_cmd_valid | output | NUM_BANKS | Per-bank strobe for the accepted request |
| bank_cmd_we | output | 1 | Operation of the accepted request |
| bank_cmd_off | output | OFF_W | In-bank word offset |
| bank_cmd_wdata | output | DATA_W | Write data sent to the bank |
| rd_valid | output | 1 | Read return present |
| rd_bank | output | BANK_W | Bank that produced the return |
| rd_data | output | DATA_W | Returned word |

## Verification
The hardest case to reach from the ports is a stall that depends on how far a busy window has already run down. The wait a request sees is set by how long ago its bank last accepted, not by the request itself. The bench drives back-to-back request sequences: same-bank triples, stride-8 sweeps, ascending and descending full sweeps, and a rewrite followed by an immediate read of the same word. It keeps its own per-bank "free from" cycle and predicts every stall length from it. Read returns are matched against a queue of expected (cycle, bank, data) entries that the bench fills as it issues reads.

// File: rtl/pmi_pkg.sv
package pmi_pkg;

    // Generic residue: shift one address bit in at a time, keep the running
    // value below the modulus. No divider, depth grows with the address width.
    function automatic int unsigned mod_by_bits(input logic [31:0] v,
                                                input int unsigned modulus);
        int unsigned acc;
        acc = 0;
        for (int i = 31; i >= 0; i--) begin
            acc = (acc << 1) | 32'(v[i]);
            if (acc >= modulus) acc = acc - modulus;
        end
        return acc;
    endfunction

    // Residue modulo 3: since 4 == 1 (mod 3), every 2-bit digit carries
    // weight one, so the digits are added and the small sum folded again.
    function automatic int unsigned mod3_by_digits(input logic [31:0] v);
        int unsigned s;
        s = 0;
        for (int i = 0; i < 16; i++) begin
            s = s + 32'(v[2*i +: 2]);
        end
        s = 32'(s[1:0]) + 32'(s[3:2]) + 32'(s[5:4]);
        if (s >= 6) s = s - 6;
        if (s >= 3) s = s - 3;
        return s;
    endfunction

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } pmi_op_e;

endpackage

// File: rtl/pmi_addr_map.sv
module pmi_addr_map #(
    parameter int unsigned NUM_BANKS      = 3,
    parameter int unsigned ADDR_W         = 5,
    parameter int unsigned BANK_W         = 2,
    parameter int unsigned OFF_W          = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [OFF_W-1:0]  off_o
);
    import pmi_pkg::*;

    logic [31:0] addr_wide;
    assign addr_wide = 32'(addr_i);

    // In-bank offset: power-of-two depth, so the low bits are the residue.
    assign off_o = addr_i[OFF_W-1:0];

    generate
        if (NUM_BANKS == 3) begin : g_mod3
            always_comb begin
                bank_o = BANK_W'(mod3_by_digits(addr_wide));
            end
        end else begin : g_generic
            always_comb begin
                bank_o = BANK_W'(mod_by_bits(addr_wide, NUM_BANKS));
            end
        end
    endgenerate

endmodule

// File: rtl/pmi_bank.sv
module pmi_bank #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned OFF_W    = 3,
    parameter int unsigned BUSY_CYC = 3,
    parameter int unsigned READ_LAT = 2,
    localparam int unsigned WORDS   = 1 << OFF_W,
    localparam int unsigned CNT_W   = $clog2(BUSY_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    input  logic              cmd_we_i,
    input  logic [OFF_W-1:0]  cmd_off_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    output logic              busy_o,
    output logic              ret_valid_o,
    output logic [DATA_W-1:0] ret_data_o
);
    import pmi_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rd_stage_t;

    logic [CNT_W-1:0]  hold_q;
    logic [DATA_W-1:0] mem_q [WORDS];
    rd_stage_t         pipe_q [READ_LAT];
    pmi_op_e           op;

    assign op     = pmi_op_e'(cmd_we_i);
    assign busy_o = (hold_q != '0);

    // Busy window: loaded on accept, counts down to zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (cmd_valid_i) begin
            hold_q <= CNT_W'(BUSY_CYC - 1);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    // Storage array.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[w] <= '0;
            end
        end else if (cmd_valid_i && op == OP_WRITE) begin
            mem_q[cmd_off_i] <= cmd_wdata_i;
        end
    end

    // Fixed-latency read pipe.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < READ_LAT; s++) begin
                pipe_q[s] <= '0;
            end
        end else begin
            pipe_q[0].vld  <= cmd_valid_i && (op == OP_READ);
            pipe_q[0].data <= mem_q[cmd_off_i];
            for (int s = 1; s < READ_LAT; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign ret_valid_o = pipe_q[READ_LAT-1].vld;
    assign ret_data_o  = pipe_q[READ_LAT-1].data;

    // R5
    bank_idle_on_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_i |-> !busy_o);

    generate
        if (BUSY_CYC > 1) begin : g_busy_chk
            // R5
            bank_busy_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
                cmd_valid_i |=> busy_o);
        end
    endgenerate

    // R7
    write_no_return_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && cmd_we_i) |=> !pipe_q[0].vld);

endmodule

// File: rtl/pmi_ret_mux.sv
module pmi_ret_mux #(
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned BANK_W    = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_BANKS-1:0]          valid_i,
    input  logic [NUM_BANKS*DATA_W-1:0]   data_i,
    output logic                          rd_valid_o,
    output logic [BANK_W-1:0]             rd_bank_o,
    output logic [DATA_W-1:0]             rd_data_o
);
    always_comb begin
        rd_valid_o = 1'b0;
        rd_bank_o  = '0;
        rd_data_o  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (valid_i[b]) begin
                rd_valid_o = 1'b1;
                rd_bank_o  = BANK_W'(b);
                rd_data_o  = data_i[b*DATA_W +: DATA_W];
            end
        end
    end

    // R7
    single_return_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(valid_i));

endmodule

// File: rtl/pmi_bank_front.sv
module pmi_bank_front #(
    parameter int unsigned NUM_BANKS      = 3,
    parameter int unsigned WORDS_PER_BANK = 8,
    parameter int unsigned DATA_W         = 16,
    parameter int unsigned BUSY_CYC       = 3,
    parameter int unsigned READ_LAT       = 2,
    localparam int unsigned TOTAL_WORDS   = NUM_BANKS * WORDS_PER_BANK,
    localparam int unsigned ADDR_W        = $clog2(TOTAL_WORDS),
    localparam int unsigned BANK_W        = $clog2(NUM_BANKS),
    localparam int unsigned OFF_W         = $clog2(WORDS_PER_BANK)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic [NUM_BANKS-1:0]  bank_cmd_valid,
    output logic                  bank_cmd_we,
    output logic [OFF_W-1:0]      bank_cmd_off,
    output logic [DATA_W-1:0]     bank_cmd_wdata,
    output logic                  rd_valid,
    output logic [BANK_W-1:0]     rd_bank,
    output logic [DATA_W-1:0]     rd_data
);
    logic [BANK_W-1:0]           sel_bank;
    logic [OFF_W-1:0]            sel_off;
    logic [NUM_BANKS-1:0]        bank_busy;
    logic [NUM_BANKS-1:0]        ret_valid;
    logic [NUM_BANKS*DATA_W-1:0] ret_data;
    logic                        sel_busy;
    logic                        fire;

    pmi_addr_map #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W),
        .OFF_W     (OFF_W)
    ) u_map (
        .addr_i (req_addr),
        .bank_o (sel_bank),
        .off_o  (sel_off)
    );

    always_comb begin
        sel_busy = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (BANK_W'(b) == sel_bank) sel_busy = bank_busy[b];
        end
    end

    assign req_ready      = !sel_busy;
    assign fire           = req_valid && req_ready;
    assign bank_cmd_we    = req_we;
    assign bank_cmd_off   = sel_off;
    assign bank_cmd_wdata = req_wdata;

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            assign bank_cmd_valid[g] = fire && (sel_bank == BANK_W'(g));

            pmi_bank #(
                .DATA_W   (DATA_W),
                .OFF_W    (OFF_W),
                .BUSY_CYC (BUSY_CYC),
                .READ_LAT (READ_LAT)
            ) u_bank (
                .clk         (clk),
                .rst         (rst),
                .cmd_valid_i (bank_cmd_valid[g]),
                .cmd_we_i    (req_we),
                .cmd_off_i   (sel_off),
                .cmd_wdata_i (req_wdata),
                .busy_o      (bank_busy[g]),
                .ret_valid_o (ret_valid[g]),
                .ret_data_o  (ret_data[g*DATA_W +: DATA_W])
            );
        end
    endgenerate

    pmi_ret_mux #(
        .NUM_BANKS (NUM_BANKS),
        .DATA_W    (DATA_W),
        .BANK_W    (BANK_W)
    ) u_ret (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (ret_valid),
        .data_i     (ret_data),
        .rd_valid_o (rd_valid),
        .rd_bank_o  (rd_bank),
        .rd_data_o  (rd_data)
    );

    // R3
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_cmd_valid));

    // R1
    map_residue_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> ((32'(req_addr) % NUM_BANKS) == 32'(sel_bank)));

    // R4
    addr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> (32'(req_addr) < TOTAL_WORDS));

    // R5
    stall_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |-> (bank_cmd_valid == '0));

endmodule

// File: tb/pmi_bank_front_tb.sv
module pmi_bank_front_tb;
    localparam int NB    = 3;
    localparam int WPB   = 8;
    localparam int DW    = 16;
    localparam int BUSY  = 3;
    localparam int LAT   = 2;
    localparam int TOTAL = NB * WPB;
    localparam int AW    = 5;
    localparam int BW    = 2;
    localparam int OW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NB-1:0] bank_cmd_valid;
    logic          bank_cmd_we;
    logic [OW-1:0] bank_cmd_off;
    logic [DW-1:0] bank_cmd_wdata;
    logic          rd_valid;
    logic [BW-1:0] rd_bank;
    logic [DW-1:0] rd_data;

    always #2 clk = ~clk;

    pmi_bank_front u_dut (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_we         (req_we),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .bank_cmd_valid (bank_cmd_valid),
        .bank_cmd_we    (bank_cmd_we),
        .bank_cmd_off   (bank_cmd_off),
        .bank_cmd_wdata (bank_cmd_wdata),
        .rd_valid       (rd_valid),
        .rd_bank        (rd_bank),
        .rd_data        (rd_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;
    bit done  = 1'b0;

    logic [DW-1:0] model_mem [TOTAL];
    int            free_at   [NB];
    bit            seen      [NB*WPB];
    int            exp_cyc   [256];
    int            exp_bank  [256];
    logic [DW-1:0] exp_data  [256];
    int            q_head = 0;
    int            q_tail = 0;

    always @(posedge clk) edges <= edges + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after accept.
    task automatic issue(input int addr, input bit we, input logic [DW-1:0] d,
                         output int waited);
        int b, o, want;
        b = addr % NB;
        o = addr % WPB;
        want = free_at[b] - edges;
        if (want < 0) want = 0;
        waited = 0;
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = AW'(addr);
        req_wdata = d;
        #1;
        while (!req_ready && waited < 50) begin
            chk("R5 no strobe while stalled", int'(bank_cmd_valid), 0);
            waited++;
            @(negedge clk);
            #1;
        end
        chk("R5 stall length", waited, want);
        chk("R1 bank strobe", int'(bank_cmd_valid), 1 << b);
        chk("R2 offset", int'(bank_cmd_off), o);
        chk("R3 op", int'(bank_cmd_we), int'(we));
        if (we) chk("R3 wdata", int'(bank_cmd_wdata), int'(d));
        free_at[b] = edges + BUSY;
        if (we) begin
            model_mem[addr] = d;
        end else begin
            exp_cyc[q_tail]  = edges + LAT;
            exp_bank[q_tail] = b;
            exp_data[q_tail] = model_mem[addr];
            q_tail++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Return-channel monitor (R6, R7).
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (rd_valid) begin
                if (q_head < q_tail) begin
                    chk("R6 return cycle", edges, exp_cyc[q_head]);
                    chk("R7 return bank", int'(rd_bank), exp_bank[q_head]);
                    chk("R6 return data", int'(rd_data), int'(exp_data[q_head]));
                    q_head++;
                end else begin
                    chk("R7 unexpected return", 1, 0);
                end
            end else if (q_head < q_tail && exp_cyc[q_head] == edges) begin
                chk("R6 missing return", 0, 1);
                q_head++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int w;
        for (int i = 0; i < TOTAL; i++) model_mem[i] = '0;
        for (int i = 0; i < NB; i++) free_at[i] = 0;
        for (int i = 0; i < NB*WPB; i++) seen[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R5 ready after reset", int'(req_ready), 1);
        chk("R3 no strobe after reset", int'(bank_cmd_valid), 0);
        chk("R6 no return after reset", int'(rd_valid), 0);
        @(negedge clk);

        // R6: unwritten word reads as zero
        issue(5, 1'b0, '0, w);
        repeat (4) @(negedge clk);

        // R1 R2: worked examples
        issue(16, 1'b0, '0, w);
        issue(8,  1'b0, '0, w);
        issue(9,  1'b0, '0, w);
        issue(23, 1'b0, '0, w);
        repeat (4) @(negedge clk);

        // R4 R5: ascending write sweep, no stalls, unique pairs
        for (int a = 0; a < TOTAL; a++) begin
            issue(a, 1'b1, DW'(a * 37 + 5), w);
            chk("R5 sequential no stall", w, 0);
            chk("R4 pair unused", int'(seen[(a % NB) * WPB + (a % WPB)]), 0);
            seen[(a % NB) * WPB + (a % WPB)] = 1'b1;
        end
        repeat (4) @(negedge clk);

        // R6 R7: descending read sweep
        for (int a = TOTAL - 1; a >= 0; a--) begin
            issue(a, 1'b0, '0, w);
        end
        repeat (4) @(negedge clk);

        // R5: same bank back-to-back waits, other bank does not
        issue(0, 1'b0, '0, w);
        issue(3, 1'b0, '0, w);
        chk("R5 same-bank wait", w, BUSY - 1);
        issue(6, 1'b0, '0, w);
        chk("R5 same-bank wait", w, BUSY - 1);
        issue(1, 1'b0, '0, w);
        chk("R5 other bank free", w, 0);
        repeat (4) @(negedge clk);

        // R5: stride-8 visits three banks without waiting
        issue(0,  1'b0, '0, w);
        chk("R5 stride8 no stall", w, 0);
        issue(8,  1'b0, '0, w);
        chk("R5 stride8 no stall", w, 0);
        issue(16, 1'b0, '0, w);
        chk("R5 stride8 no stall", w, 0);

        // R6: rewrite then read same word
        issue(9, 1'b1, 16'hBEEF, w);
        issue(9, 1'b0, '0, w);
        chk("R5 rewrite-read wait", w, BUSY - 1);
        issue(17, 1'b1, 16'h1234, w);
        issue(17, 1'b0, '0, w);

        repeat (LAT + 4) @(negedge clk);
        chk("R7 all returns seen", q_head, q_tail);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule